// File: doc/BRIEF.md
# Prescaled Backlight PWM Generator

A single-channel pulse-width modulator meant for driving a display backlight. Software writes one 16-bit configuration word that holds an 8-bit compare value, a polarity flag and a 3-bit prescaler exponent. It then starts or stops the generator with separate one-cycle set and clear strobes, and polls a running flag that trails those strobes. A separate select bit chooses the counting source. With the bit at 0, the counter advances only on cycles where an external slow clock-enable is high. With the bit at 1, it advances on every system clock.

Each output period lasts 256 prescaled ticks. A tick is 2^ps counting-source cycles, with ps limited to the range 0..6. The output is active for the first `cmp` ticks of every period, so the duty cycle runs from 0/256 to 255/256 and a fully active output does not exist. While the generator runs, new configuration values wait in a shadow copy and take effect only when the next period begins. An optional build parameter forbids a divider of 1.

Top module: `bl_pwm`

## Requirements
- R1: After reset the generator is stopped, `running_o` is 0, every configuration field is 0 and `pwm_o` is 1, which is the idle level for polarity 0.
- R2: Configuration word layout: bits 15:8 hold the compare value, bit 4 the polarity and bits 2:0 the prescaler exponent ps. One period lasts 256·2^ps counting-source cycles.
- R3: A written exponent of 7 is stored as 6.
- R4: With polarity 1, the output is high for exactly `cmp` of the 256 ticks in each period. Compare 0 gives a constant low and compare 255 gives 255/256, never a constant high.
- R5: Polarity 1 drives high while the tick counter is below the compare value. Polarity 0 inverts the output. While stopped, the output holds the idle level: 0 for polarity 1 and 1 for polarity 0.
- R6: With select 1 the counter advances on every clock. With select 0 it advances only on cycles where `slow_tick_i` is 1.
- R7: A set strobe sampled at one clock edge raises `running_o` at the second edge after it. Counting then starts from tick 0.
- R8: After a clear strobe, `running_o` and the output keep running until the current period ends. The generator stops at the edge where the last tick of that period completes.
- R9: If set and clear strobes arrive in the same cycle, clear wins: a stopped generator does not start.
- R10: While running, a configuration write takes effect only at the next period boundary. While stopped, it takes effect within two cycles.
- R11: With parameter NO_DIV1 set, a written exponent of 0 is stored as 1. Reset then also loads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| slow_tick_i | input | 1 | Slow clock-enable, used when select is 0 |
| cfg_we_i | input | 1 | Write strobe for the configuration word |
| cfg_word_i | input | 16 | Configuration word (compare, polarity, exponent) |
| sel_we_i | input | 1 | Write strobe for the source select |
| sel_i | input | 1 | Source select: 0 slow enable, 1 system clock |
| en_set_i | input | 1 | Start strobe |
| en_clr_i | input | 1 | Stop strobe |
| pwm_o | output | 1 | PWM output |
| running_o | output | 1 | Running status |

## Verification
The bench checks the start latency cycle by cycle. A design that raised the status one edge early or one edge late would show up there. It checks a stop requested right at the start of a period, which must keep the output alive for exactly 255 more cycles. A design that stopped at once, or one period too late, fails this check. A mid-period compare write must leave the rest of that period's pulse unchanged, which exposes a missing shadow copy. Duty counts at compare values 0 and 255, an exponent of 7, and the slow-enable source catch a counter that saturates wrongly or a prescaler that is off by one. A second instance built with NO_DIV1 has its period measured, which catches a design that still divides by 1.

// File: rtl/bl_pwm_pkg.sv
package bl_pwm_pkg;
  localparam int unsigned CMP_W   = 8;
  localparam int unsigned PS_W    = 3;
  localparam int unsigned PS_MAX  = 6;
  localparam int unsigned WORD_W  = 16;
  localparam int unsigned CMP_LSB = WORD_W - CMP_W;
  localparam int unsigned POL_BIT = 4;

  typedef struct packed {
    logic [CMP_W-1:0] cmp;
    logic             pol;
    logic [PS_W-1:0]  ps;
  } pwm_cfg_t;

  function automatic logic [PS_W-1:0] legal_ps(input logic [PS_W-1:0] raw, input bit no_div1);
    logic [PS_W-1:0] v;
    v = (raw > PS_W'(PS_MAX)) ? PS_W'(PS_MAX) : raw;
    if (no_div1 && v == '0) v = PS_W'(1);
    return v;
  endfunction
endpackage

// File: rtl/bl_pwm_cfg.sv
module bl_pwm_cfg
  import bl_pwm_pkg::*;
#(
  parameter bit NO_DIV1 = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [WORD_W-1:0] cfg_word_i,
  input  logic              sel_we_i,
  input  logic              sel_i,
  input  logic              run_i,
  input  logic              wrap_i,
  output pwm_cfg_t          act_o,
  output logic              sel_o
);
  localparam logic [PS_W-1:0] PS_RST = NO_DIV1 ? PS_W'(1) : '0;
  localparam pwm_cfg_t CFG_RST = '{cmp: '0, pol: 1'b0, ps: PS_RST};

  pwm_cfg_t cfg_q, act_q;
  logic     sel_q;
  logic     unused_bits;

  assign unused_bits = ^{cfg_word_i[CMP_LSB-1:POL_BIT+1], cfg_word_i[POL_BIT-1:PS_W]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= CFG_RST;
      act_q <= CFG_RST;
      sel_q <= 1'b0;
    end else begin
      if (cfg_we_i)
        cfg_q <= '{cmp: cfg_word_i[WORD_W-1:CMP_LSB],
                   pol: cfg_word_i[POL_BIT],
                   ps:  legal_ps(cfg_word_i[PS_W-1:0], NO_DIV1)};
      if (sel_we_i) sel_q <= sel_i;
      // shadow follows freely when idle, otherwise only at period boundary
      if (!run_i || wrap_i) act_q <= cfg_q;
    end
  end

  assign act_o = act_q;
  assign sel_o = sel_q;

  assert_ps_cap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_q.ps <= PS_W'(PS_MAX));

  assert_shadow_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && !wrap_i |=> $stable(act_q));

  if (NO_DIV1) begin : g_nodiv1
    assert_no_div1_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      act_q.ps != '0);
  end
endmodule

// File: rtl/bl_pwm_ctrl.sv
module bl_pwm_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_set_i,
  input  logic en_clr_i,
  input  logic wrap_i,
  output logic run_o
);
  logic pend_q, stop_q, run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      stop_q <= 1'b0;
      run_q  <= 1'b0;
    end else begin
      pend_q <= en_set_i & ~en_clr_i & ~run_q;
      if (run_q) begin
        if (wrap_i && (stop_q || en_clr_i)) run_q <= 1'b0;
      end else if (pend_q && !en_clr_i) begin
        run_q <= 1'b1;
      end
      if (!run_q || wrap_i) stop_q <= 1'b0;
      else if (en_clr_i)    stop_q <= 1'b1;
      else if (en_set_i)    stop_q <= 1'b0;
    end
  end

  assign run_o = run_q;

  assert_start_path_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_q) |-> $past(pend_q));

  assert_pend_start_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q && !en_clr_i |=> run_q);

  assert_stop_at_wrap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(run_q) |-> $past(wrap_i));

  assert_clr_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_set_i && en_clr_i && !run_q |=> !pend_q && !run_q);
endmodule

// File: rtl/bl_pwm_timebase.sv
module bl_pwm_timebase #(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned PS_W  = 3,
  parameter int unsigned PRE_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic [PS_W-1:0]  ps_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  logic [PRE_W-1:0] pre_q, pre_lim;
  logic [CNT_W-1:0] cnt_q;
  logic             last_sub;

  assign pre_lim  = PRE_W'((32'd1 << ps_i) - 32'd1);
  assign last_sub = tick_i && (pre_q == pre_lim);
  assign wrap_o   = run_i && last_sub && (&cnt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else if (!run_i) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else if (tick_i) begin
      if (last_sub) begin
        pre_q <= '0;
        cnt_q <= cnt_q + 1'b1;
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end

  assign cnt_o = cnt_q;

  assert_pre_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> pre_q <= pre_lim);

  assert_idle_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> cnt_q == '0);
endmodule

// File: rtl/bl_pwm.sv
module bl_pwm
  import bl_pwm_pkg::*;
#(
  parameter bit NO_DIV1 = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              slow_tick_i,
  input  logic              cfg_we_i,
  input  logic [WORD_W-1:0] cfg_word_i,
  input  logic              sel_we_i,
  input  logic              sel_i,
  input  logic              en_set_i,
  input  logic              en_clr_i,
  output logic              pwm_o,
  output logic              running_o
);
  pwm_cfg_t         act;
  logic             sel, run, wrap, tick;
  logic [CMP_W-1:0] cnt;

  bl_pwm_cfg #(.NO_DIV1(NO_DIV1)) u_cfg (
    .clk_i(clk_i), .rst_ni(rst_ni), .cfg_we_i(cfg_we_i), .cfg_word_i(cfg_word_i),
    .sel_we_i(sel_we_i), .sel_i(sel_i), .run_i(run), .wrap_i(wrap),
    .act_o(act), .sel_o(sel)
  );

  bl_pwm_ctrl u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_set_i(en_set_i), .en_clr_i(en_clr_i),
    .wrap_i(wrap), .run_o(run)
  );

  assign tick = run && (sel || slow_tick_i);

  bl_pwm_timebase #(.CNT_W(CMP_W), .PS_W(PS_W), .PRE_W(PS_MAX)) u_tb (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run), .tick_i(tick), .ps_i(act.ps),
    .cnt_o(cnt), .wrap_o(wrap)
  );

  assign pwm_o     = (run && (cnt < act.cmp)) ? act.pol : ~act.pol;
  assign running_o = run;

  assert_never_full_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run && (&cnt) |-> pwm_o == ~act.pol);
endmodule

// File: tb/sim_bl_pwm.sv
module sim_bl_pwm;
  logic clk = 1'b0, rst_n = 1'b0;
  logic slow = 1'b0, cfg_we = 1'b0, sel_we = 1'b0, sel = 1'b0, en_set = 1'b0, en_clr = 1'b0;
  logic [15:0] cfg_word = '0;
  logic pwm0, run0, pwm1, run1;
  int n_checks = 0, n_fail = 0;
  string sect = "";
  int mism = 0;

  always #2 clk = ~clk;

  bl_pwm u0 (.clk_i(clk), .rst_ni(rst_n), .slow_tick_i(slow), .cfg_we_i(cfg_we),
    .cfg_word_i(cfg_word), .sel_we_i(sel_we), .sel_i(sel), .en_set_i(en_set),
    .en_clr_i(en_clr), .pwm_o(pwm0), .running_o(run0));

  bl_pwm #(.NO_DIV1(1'b1)) u1 (.clk_i(clk), .rst_ni(rst_n), .slow_tick_i(slow), .cfg_we_i(cfg_we),
    .cfg_word_i(cfg_word), .sel_we_i(sel_we), .sel_i(sel), .en_set_i(en_set),
    .en_clr_i(en_clr), .pwm_o(pwm1), .running_o(run1));

  // slow enable: high one cycle in four
  int ph = 0;
  always @(negedge clk) begin
    ph = (ph + 1) % 4;
    slow = (ph == 3);
  end

  // behavioural reference model for u0
  int m_cmp, m_pol, m_ps, a_cmp, a_pol, a_ps, m_sel, m_run, m_pend, m_stop, m_cnt, m_pre;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cmp = 0; m_pol = 0; m_ps = 0; a_cmp = 0; a_pol = 0; a_ps = 0;
      m_sel = 0; m_run = 0; m_pend = 0; m_stop = 0; m_cnt = 0; m_pre = 0;
    end else begin
      bit tk, wr;
      int lim, n_run, n_pend, n_stop;
      tk  = (m_run != 0) && (m_sel != 0 || slow);
      lim = (1 << a_ps) - 1;
      wr  = tk && m_pre == lim && m_cnt == 255;
      n_pend = (en_set && !en_clr && m_run == 0) ? 1 : 0;
      n_run = m_run;
      if (m_run != 0) begin
        if (wr && (m_stop != 0 || en_clr)) n_run = 0;
      end else if (m_pend != 0 && !en_clr) n_run = 1;
      n_stop = m_stop;
      if (m_run == 0 || wr) n_stop = 0;
      else if (en_clr) n_stop = 1;
      else if (en_set) n_stop = 0;
      if (m_run == 0) begin m_cnt = 0; m_pre = 0; end
      else if (tk) begin
        if (m_pre == lim) begin m_pre = 0; m_cnt = (m_cnt + 1) % 256; end
        else m_pre = m_pre + 1;
      end
      if (m_run == 0 || wr) begin a_cmp = m_cmp; a_pol = m_pol; a_ps = m_ps; end
      if (cfg_we) begin
        m_cmp = cfg_word[15:8]; m_pol = cfg_word[4]; m_ps = cfg_word[2:0];
        if (m_ps > 6) m_ps = 6;
      end
      if (sel_we) m_sel = sel;
      m_run = n_run; m_pend = n_pend; m_stop = n_stop;
    end
  end

  always @(negedge clk) begin
    if (rst_n && sect != "") begin
      bit e_pwm;
      e_pwm = (m_run != 0 && m_cnt < a_cmp) ? (a_pol != 0) : (a_pol == 0);
      if (pwm0 !== e_pwm || run0 !== (m_run != 0)) mism++;
    end
  end

  task automatic check(string req, bit ok, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic begin_sect(string r);
    if (sect != "") check({sect, " cycle model mismatches"}, mism == 0, mism, 0);
    sect = r;
    mism = 0;
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_cfg(int cmp, int pol, int ps);
    cfg_word = {cmp[7:0], 3'b000, pol[0], 1'b0, ps[2:0]};
    cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wr_sel(bit s);
    sel = s; sel_we = 1'b1;
    @(negedge clk);
    sel_we = 1'b0;
  endtask

  task automatic strobe(bit s, bit c);
    en_set = s; en_clr = c;
    @(negedge clk);
    en_set = 1'b0; en_clr = 1'b0;
  endtask

  task automatic count_high(int n, output int h);
    h = 0;
    repeat (n) begin
      @(negedge clk);
      if (pwm0) h++;
    end
  endtask

  task automatic wait_rise0();
    bit prev;
    prev = pwm0;
    for (int i = 0; i < 70000; i++) begin
      @(negedge clk);
      if (!prev && pwm0) break;
      prev = pwm0;
    end
  endtask

  task automatic stop_and_wait();
    strobe(1'b0, 1'b1);
    for (int i = 0; i < 70000 && run0; i++) @(negedge clk);
    check("R8 stopped after period end", run0 == 1'b0, run0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    int h;
    step(3);
    rst_n = 1'b1;
    step(1);
    // R1 reset state
    check("R1 running after reset", run0 == 1'b0, run0, 0);
    check("R1 idle level after reset", pwm0 == 1'b1, pwm0, 1);

    begin_sect("R5");
    wr_sel(1'b1);
    wr_cfg(64, 1, 0);
    step(1);
    check("R5 idle level polarity 1", pwm0 == 1'b0, pwm0, 0);

    begin_sect("R7");
    strobe(1'b1, 1'b0);
    check("R7 status one edge after set", run0 == 1'b0, run0, 0);
    step(1);
    check("R7 status two edges after set", run0 == 1'b1, run0, 1);

    begin_sect("R4");
    count_high(256, h);
    check("R4 duty cmp 64", h == 64, h, 64);

    begin_sect("R8");
    wait_rise0();
    strobe(1'b0, 1'b1);
    check("R8 still running after clear", run0 == 1'b1, run0, 1);
    step(254);
    check("R8 running on last tick", run0 == 1'b1, run0, 1);
    step(1);
    check("R8 stopped at period end", run0 == 1'b0, run0, 0);
    check("R5 idle level after stop", pwm0 == 1'b0, pwm0, 0);

    begin_sect("R4");
    strobe(1'b1, 1'b0);
    wr_cfg(255, 1, 0);
    step(600);
    count_high(256, h);
    check("R4 duty cmp 255 never full", h == 255, h, 255);
    wr_cfg(0, 1, 0);
    step(600);
    count_high(256, h);
    check("R4 duty cmp 0", h == 0, h, 0);

    begin_sect("R5");
    wr_cfg(64, 0, 0);
    step(600);
    count_high(256, h);
    check("R5 inverted polarity", h == 192, h, 192);

    begin_sect("R2");
    wr_cfg(64, 1, 2);
    step(1100);
    count_high(1024, h);
    check("R2 exponent 2 period", h == 256, h, 256);

    begin_sect("R3");
    wr_cfg(128, 1, 7);
    step(1100);
    count_high(16384, h);
    check("R3 exponent 7 clamped to 6", h == 8192, h, 8192);
    stop_and_wait();

    begin_sect("R9");
    strobe(1'b1, 1'b1);
    step(3);
    check("R9 clear wins over set", run0 == 1'b0, run0, 0);

    begin_sect("R6");
    wr_sel(1'b0);
    wr_cfg(32, 1, 0);
    step(1);
    strobe(1'b1, 1'b0);
    step(2);
    count_high(1024, h);
    check("R6 slow enable source", h == 128, h, 128);
    stop_and_wait();

    begin_sect("R10");
    wr_sel(1'b1);
    wr_cfg(200, 1, 0);
    step(1);
    strobe(1'b1, 1'b0);
    step(2);
    wait_rise0();
    step(20);
    wr_cfg(10, 1, 0);
    check("R10 old compare holds mid-period", pwm0 == 1'b1, pwm0, 1);
    step(250);
    check("R10 new compare next period", pwm0 == 1'b0, pwm0, 0);

    begin_sect("R11");
    wr_cfg(128, 1, 0);
    strobe(1'b1, 1'b0);
    step(1200);
    check("R11 no-div1 instance running", run1 == 1'b1, run1, 1);
    begin
      bit prev;
      int per;
      prev = pwm1;
      for (int i = 0; i < 2000; i++) begin
        @(negedge clk);
        if (!prev && pwm1) break;
        prev = pwm1;
      end
      per = 0;
      prev = pwm1;
      for (int i = 0; i < 2000; i++) begin
        @(negedge clk);
        per++;
        if (!prev && pwm1) break;
        prev = pwm1;
      end
      check("R11 exponent 0 runs as 1", per == 512, per, 512);
    end
    count_high(256, h);
    check("R11 default instance keeps divide-by-1", h == 128, h, 128);

    begin_sect("");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule